// File: doc/BRIEF.md
# LCD raster timing generator

This block sequences the horizontal and vertical timing of a parallel TFT panel. It produces horizontal and vertical sync, a data-enable, the pixel column and line of the current active pixel, and one-cycle pulses that mark the first pixel and the last clock of each frame. It runs on the pixel clock, so one clock is one pixel slot.

Panel geometry arrives through a simple write port as three 32-bit configuration words. Several fields are split across words, and most counts are stored as the real value minus one. Writes land in shadow storage. The running geometry is taken from the shadow only on the clock edge that begins a frame, so a frame never changes shape part-way through.

Raising `raster_en` starts scanning. Lowering it does not cut a frame short: the frame in progress runs to its end, raises `frame_done`, and only then does the block go idle. If `raster_en` is high again by that final edge, the next frame follows with no gap. The sync outputs are active-high unless a parameter inverts them. There is no data stream through this block, so every pin is a plain control or status pin with no handshake.

Top module: `lcd_raster_timing`

## Requirements
- R1: While reset is held, and while the block is idle, `de`, `frame_start` and `frame_done` are 0, `pix_x` and `pix_y` are 0, and `hsync` and `vsync` are at their inactive level (0 by default). The clock edge that first sees `raster_en` high while idle begins a frame, and that frame's first active pixel is visible right after that edge.
- R2: Each line is, in order, active pixels, then front porch, then sync, then back porch. `hsync` is asserted exactly during the sync slots. The line counter advances after the last back-porch slot.
- R3: The active width is (F+1)*16 pixels. F is the 7-bit value whose bits 5..0 sit at word 0 bits [9:4] and whose bit 6 sits at word 0 bit 3.
- R4: The horizontal front porch, sync width and back porch each last their 10-bit stored value plus one.
  - Front porch: low 8 bits at word 0 [23:16], high 2 bits at word 2 [1:0].
  - Sync width: low 6 bits at word 0 [15:10], high 4 bits at word 2 [30:27].
  - Back porch: low 8 bits at word 0 [31:24], high 2 bits at word 2 [5:4].
- R5: A frame is, in order, active lines, then front-porch lines, then sync lines, then back-porch lines.
  - The active line count is the 11-bit stored value plus one: bits 9..0 at word 1 [9:0], bit 10 at word 2 bit 26.
  - The front-porch count (word 1 [23:16]) and the back-porch count (word 1 [31:24]) are literal; a count of 0 removes that phase.
  - The sync line count is word 1 [15:10] plus one.
  - `vsync` is asserted exactly during the sync lines.
- R6: `de` is 1 only when both the pixel and the line lie in their active regions. `pix_x` counts 0 upward across the active pixels of a line and is 0 elsewhere. `pix_y` counts 0 upward across the active lines and is 0 elsewhere.
- R7: `frame_start` pulses for one cycle on the first active pixel (column 0, line 0) of every frame.
- R8: `frame_done` pulses for one cycle on the last clock of every frame. If `raster_en` is low on that clock, the block goes idle afterwards. If `raster_en` is high on that clock, the next frame starts immediately, even if `raster_en` was low earlier in the frame.
- R9: Writes to word 0, 1 and 2 (selector values 0, 1, 2) land in shadow storage. Geometry takes effect only from the next frame start; the frame in progress keeps its geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Configuration word selector (0, 1, 2) |
| cfg_wr_data | input | 32 | Configuration word value |
| raster_en | input | 1 | Request to scan frames |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, high on active pixels |
| pix_x | output | 11 | Active pixel column |
| pix_y | output | 11 | Active line number |
| frame_start | output | 1 | Pulse on the first active pixel of a frame |
| frame_done | output | 1 | Pulse on the last clock of a frame |

## Verification
All outputs decode registered counter state, so each result is due in the cycle right after the edge that caused it. The first pixel shows just after the edge that sees `raster_en` high. Every later slot of a frame is due exactly t cycles after that edge. Shadow writes show up only in the frame that starts after them. The bench drives inputs and samples outputs on the falling clock edge, and compares every sampled cycle against a model indexed by the cycle count since the frame-start edge. That model is built from the phase lengths alone, so a slip of a single slot anywhere in a frame is reported on the cycle where it happens.

// File: rtl/lcd_rtg_pkg.sv
package lcd_rtg_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;

  // Decoded geometry; *_m1 fields hold count minus one.
  typedef struct packed {
    logic [10:0] hact_m1;
    logic [9:0]  hfp_m1;
    logic [9:0]  hsw_m1;
    logic [9:0]  hbp_m1;
    logic [10:0] vact_m1;
    logic [7:0]  vfp;
    logic [5:0]  vsw_m1;
    logic [7:0]  vbp;
  } geom_t;

  function automatic geom_t decode_geom(input logic [WORD_W-1:0] w0,
                                        input logic [WORD_W-1:0] w1,
                                        input logic [WORD_W-1:0] w2);
    geom_t g;
    // width in 16-pixel units minus one -> pixels minus one
    g.hact_m1 = {w0[3], w0[9:4], 4'hF};
    g.hfp_m1  = {w2[1:0], w0[23:16]};
    g.hsw_m1  = {w2[30:27], w0[15:10]};
    g.hbp_m1  = {w2[5:4], w0[31:24]};
    g.vact_m1 = {w2[26], w1[9:0]};
    g.vfp     = w1[23:16];
    g.vsw_m1  = w1[15:10];
    g.vbp     = w1[31:24];
    return g;
  endfunction

endpackage

// File: rtl/lcd_rtg_cfg.sv
module lcd_rtg_cfg
  import lcd_rtg_pkg::*;
#(
  parameter int DATA_W    = WORD_W,
  parameter int NUM_WORDS = 3,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output geom_t             geom
);

  logic [DATA_W-1:0] shadow [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[k] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(k))) begin
        shadow[k] <= wr_data;
      end
    end
  end

  // Running geometry only moves on a frame-start edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geom <= '0;
    end else if (load) begin
      geom <= decode_geom(WORD_W'(shadow[0]), WORD_W'(shadow[1]), WORD_W'(shadow[2]));
    end
  end

endmodule

// File: rtl/lcd_rtg_hseq.sv
module lcd_rtg_hseq
  import lcd_rtg_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  geom_t         geom,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          line_end
);

  logic [CW-1:0] lim;
  logic          wrap;
  phase_e        nxt;

  always_comb begin
    unique case (phase)
      PH_ACT:  begin lim = CW'(geom.hact_m1); nxt = PH_FP;   end
      PH_FP:   begin lim = CW'(geom.hfp_m1);  nxt = PH_SYNC; end
      PH_SYNC: begin lim = CW'(geom.hsw_m1);  nxt = PH_BP;   end
      default: begin lim = CW'(geom.hbp_m1);  nxt = PH_ACT;  end
    endcase
  end

  assign wrap     = (cnt == lim);
  assign line_end = run && (phase == PH_BP) && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_ACT;
      cnt   <= '0;
    end else if (wrap) begin
      phase <= nxt;
      cnt   <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/lcd_rtg_vseq.sv
module lcd_rtg_vseq
  import lcd_rtg_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  input  geom_t         geom,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          frame_end
);

  logic [CW-1:0] lim;
  logic          wrap;
  logic          last_line;
  phase_e        nxt;
  logic          has_fp;
  logic          has_bp;

  assign has_fp = (geom.vfp != '0);
  assign has_bp = (geom.vbp != '0);

  always_comb begin
    unique case (phase)
      PH_ACT: begin
        lim = CW'(geom.vact_m1);
        nxt = has_fp ? PH_FP : PH_SYNC;
      end
      PH_FP: begin
        lim = CW'(geom.vfp) - CW'(1);
        nxt = PH_SYNC;
      end
      PH_SYNC: begin
        lim = CW'(geom.vsw_m1);
        nxt = has_bp ? PH_BP : PH_ACT;
      end
      default: begin
        lim = CW'(geom.vbp) - CW'(1);
        nxt = PH_ACT;
      end
    endcase
  end

  assign wrap      = (cnt == lim);
  assign last_line = wrap && ((phase == PH_BP) || ((phase == PH_SYNC) && !has_bp));
  assign frame_end = line_end && last_line;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_ACT;
      cnt   <= '0;
    end else if (line_end) begin
      if (wrap) begin
        phase <= nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcd_rtg_pkg::*;
#(
  parameter int   CFG_W      = WORD_W,
  parameter int   SEL_W      = 2,
  parameter int   X_W        = 11,
  parameter int   Y_W        = 11,
  parameter logic HSYNC_HIGH = 1'b1,
  parameter logic VSYNC_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [SEL_W-1:0] cfg_wr_sel,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             raster_en,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [X_W-1:0]   pix_x,
  output logic [Y_W-1:0]   pix_y,
  output logic             frame_start,
  output logic             frame_done
);

  localparam int NUM_WORDS = 3;

  geom_t          geom;
  logic           run_q;
  logic           start_w;
  phase_e         hph;
  phase_e         vph;
  logic [X_W-1:0] hcnt;
  logic [Y_W-1:0] vcnt;
  logic           line_end;
  logic           frame_end;
  logic           h_act;
  logic           v_act;

  assign start_w = raster_en && (!run_q || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (!run_q) begin
      run_q <= raster_en;
    end else if (frame_end && !raster_en) begin
      run_q <= 1'b0;
    end
  end

  lcd_rtg_cfg #(
    .DATA_W(CFG_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .load(start_w), .geom(geom)
  );

  lcd_rtg_hseq #(.CW(X_W)) hseq_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .geom(geom),
    .phase(hph), .cnt(hcnt), .line_end(line_end)
  );

  lcd_rtg_vseq #(.CW(Y_W)) vseq_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .line_end(line_end), .geom(geom),
    .phase(vph), .cnt(vcnt), .frame_end(frame_end)
  );

  assign h_act       = run_q && (hph == PH_ACT);
  assign v_act       = run_q && (vph == PH_ACT);
  assign de          = h_act && v_act;
  assign pix_x       = h_act ? hcnt : '0;
  assign pix_y       = v_act ? vcnt : '0;
  assign hsync       = (run_q && (hph == PH_SYNC)) ? HSYNC_HIGH : !HSYNC_HIGH;
  assign vsync       = (run_q && (vph == PH_SYNC)) ? VSYNC_HIGH : !VSYNC_HIGH;
  assign frame_start = de && (hcnt == '0) && (vcnt == '0);
  assign frame_done  = frame_end;

endmodule

// File: rtl/lcd_raster_timing_chk.sv
module lcd_raster_timing_chk
  import lcd_rtg_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           raster_en,
  input logic           run_q,
  input logic           start_w,
  input geom_t          geom,
  input logic           de,
  input logic [X_W-1:0] pix_x,
  input logic [Y_W-1:0] pix_y,
  input logic           frame_start,
  input logic           frame_done
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!de && !frame_start && !frame_done));

  a_r7_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (de && (pix_x == '0) && (pix_y == '0)));

  a_r6_column_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (de && (pix_x != '0)) |-> ($past(de) && (pix_x == X_W'($past(pix_x) + X_W'(1)))));

  a_r8_stop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !raster_en) |=> !run_q);

  a_r8_frame_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !frame_done) |=> run_q);

  a_r9_geom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !start_w |=> $stable(geom));

endmodule

bind lcd_raster_timing lcd_raster_timing_chk #(.X_W(X_W), .Y_W(Y_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .run_q(run_q),
  .start_w(start_w), .geom(geom), .de(de), .pix_x(pix_x), .pix_y(pix_y),
  .frame_start(frame_start), .frame_done(frame_done)
);

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        raster_en = 1'b0;
  logic        hsync, vsync, de, frame_start, frame_done;
  logic [10:0] pix_x, pix_y;

  int checks = 0;
  int failures = 0;

  // current model geometry (real counts)
  int ha = 16, hf = 1, hs = 1, hb = 1, va = 1, vf = 0, vs = 1, vb = 0;
  // pending geometry
  int n_ha, n_hf, n_hs, n_hb, n_va, n_vf, n_vs, n_vb;
  logic [31:0] nw0, nw1, nw2;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_timing dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .raster_en(raster_en), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .frame_done(frame_done)
  );

  function automatic int frame_len();
    return (ha + hf + hs + hb) * (va + vf + vs + vb);
  endfunction

  function automatic logic [26:0] model(input int t);
    int l, x, y;
    logic hA, vA, hS, vS;
    l  = ha + hf + hs + hb;
    x  = t % l;
    y  = t / l;
    hA = (x < ha);
    vA = (y < va);
    hS = (x >= ha + hf) && (x < ha + hf + hs);
    vS = (y >= va + vf) && (y < va + vf + vs);
    return {hS, vS, hA && vA, t == 0, t == frame_len() - 1,
            hA ? 11'(x) : 11'd0, vA ? 11'(y) : 11'd0};
  endfunction

  function automatic logic [26:0] observed();
    return {hsync, vsync, de, frame_start, frame_done, pix_x, pix_y};
  endfunction

  task automatic check_val(input string req, input logic [26:0] act, input logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_span(input string req, input int t0, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_val(req, observed(), model(t0 + i));
    end
  endtask

  task automatic check_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_val(req, observed(), 27'd0);
    end
  endtask

  task automatic pack_geom(input int ppl7, input int hfp_m1, input int hsw_m1,
                           input int hbp_m1, input int vact_m1, input int vfp_c,
                           input int vsw_m1, input int vbp_c);
    logic [6:0] p; logic [9:0] f, s, b; logic [10:0] a;
    p = 7'(ppl7); f = 10'(hfp_m1); s = 10'(hsw_m1); b = 10'(hbp_m1); a = 11'(vact_m1);
    nw0 = {b[7:0], f[7:0], s[5:0], p[5:0], p[6], 3'b000};
    nw1 = {8'(vbp_c), 8'(vfp_c), 6'(vsw_m1), a[9:0]};
    nw2 = '0;
    nw2[1:0]   = f[9:8];
    nw2[5:4]   = b[9:8];
    nw2[30:27] = s[9:6];
    nw2[26]    = a[10];
    n_ha = (ppl7 + 1) * 16; n_hf = hfp_m1 + 1; n_hs = hsw_m1 + 1; n_hb = hbp_m1 + 1;
    n_va = vact_m1 + 1; n_vf = vfp_c; n_vs = vsw_m1 + 1; n_vb = vbp_c;
  endtask

  task automatic commit_model();
    ha = n_ha; hf = n_hf; hs = n_hs; hb = n_hb;
    va = n_va; vf = n_vf; vs = n_vs; vb = n_vb;
  endtask

  task automatic write_idle();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = 2'(k);
      cfg_wr_data = (k == 0) ? nw0 : (k == 1) ? nw1 : nw2;
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
    commit_model();
  endtask

  // Runs whole frames from idle, then stops at the last frame's end.
  task automatic run_frames(input string req, input int nframes);
    @(negedge clk);
    raster_en = 1'b1;
    for (int f = 0; f < nframes; f++) begin
      if (f == nframes - 1) begin
        check_span(req, 0, frame_len() - 1);
        raster_en = 1'b0;
        check_span(req, frame_len() - 1, 1);
      end else begin
        check_span(req, 0, frame_len());
      end
    end
    check_idle({req, " idle after stop (R8)"}, 8);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_val("R1 in reset", observed(), 27'd0);
    end
    rst_n = 1'b1;
    check_idle("R1 idle after reset", 5);
  endtask

  task automatic t_default_geom();
    // all-zero words: 16 px, porches/sync 1, 1 line, vfp 0, vsync 1, vbp 0
    run_frames("R3 R5 zero-length vertical porches", 1);
  endtask

  task automatic t_small_geom();
    pack_geom(0, 2, 1, 3, 2, 1, 0, 2);
    write_idle();
    run_frames("R2 R6 R7 line and frame order", 2);
  endtask

  task automatic t_stop_midframe();
    int fl;
    @(negedge clk);
    raster_en = 1'b1;
    fl = frame_len();
    check_span("R8 first frame", 0, fl);
    check_span("R8 before drop", 0, 30);
    raster_en = 1'b0;
    check_span("R8 frame completes after drop", 30, fl - 30);
    check_idle("R8 idle after completion", 10);
  endtask

  task automatic t_reenable();
    int fl;
    @(negedge clk);
    raster_en = 1'b1;
    fl = frame_len();
    check_span("R8 reenable", 0, 40);
    raster_en = 1'b0;
    check_span("R8 reenable low window", 40, 5);
    raster_en = 1'b1;
    check_span("R8 reenable", 45, fl - 45);
    check_span("R8 next frame follows without gap", 0, fl - 1);
    raster_en = 1'b0;
    check_span("R8 last", fl - 1, 1);
    check_idle("R8 idle", 5);
  endtask

  task automatic t_hsplit();
    // width field bit 6, porch high bits in word 2
    pack_geom(64, 10'h200, 10'h040, 10'h100, 0, 0, 0, 0);
    write_idle();
    run_frames("R3 R4 split horizontal fields", 1);
  endtask

  task automatic t_vsplit();
    pack_geom(0, 0, 0, 0, 1024, 2, 2, 1);
    write_idle();
    run_frames("R5 line count bit 10", 1);
  endtask

  task automatic t_midframe_write();
    int fl, t;
    pack_geom(0, 1, 0, 2, 1, 1, 1, 1);
    write_idle();
    @(negedge clk);
    raster_en = 1'b1;
    fl = frame_len();
    check_span("R9 old geometry", 0, 20);
    t = 20;
    pack_geom(1, 0, 2, 0, 0, 2, 0, 0);
    for (int k = 0; k < 3; k++) begin
      cfg_wr_en = 1'b1; cfg_wr_sel = 2'(k);
      cfg_wr_data = (k == 0) ? nw0 : (k == 1) ? nw1 : nw2;
      check_span("R9 frame keeps geometry during write", t, 1);
      t++;
    end
    cfg_wr_en = 1'b0;
    check_span("R9 frame keeps geometry", t, fl - t);
    commit_model();
    fl = frame_len();
    check_span("R9 new geometry next frame", 0, fl - 1);
    raster_en = 1'b0;
    check_span("R9 new geometry last slot", fl - 1, 1);
    check_idle("R9 idle", 5);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_default_geom();
    t_small_geom();
    t_stop_midframe();
    t_reenable();
    t_hsplit();
    t_vsplit();
    t_midframe_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule